// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block turns one indexed operand description into a 16-bit effective address for a small 8-bit processor core. The decoder presents a mode code, a choice of one of four pointer registers, the current pointer, accumulator and program counter values, and a constant offset, all with a one-cycle `req` strobe. The block adds the right terms and returns the address. For the auto-increment and auto-decrement forms it also returns the new value of the chosen pointer register, so that the register file can update it.

Any form can be marked indirect. The computed address then names a two-byte pointer in memory. The block reads that pointer one byte at a time through a request/acknowledge port and gives the fetched pointer as the final address. While the fetch runs, the block accepts no new request.

Top module: `eag_indexed_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `ea_valid`, `wb_valid` and `ptr_fetch_req` are 0.
- R2: A direct request with mode 0 gives the selected pointer as the address. Mode 1 adds the sign-extended low byte of `offset`, and mode 2 adds the full 16-bit `offset`. `ea_valid` is high in the cycle after `req`, and `wb_valid` is low. The pointer codes for `base_sel` are 0=X, 1=Y, 2=U and 3=S.
- R3: Modes 3 and 4 (post-increment) give the unchanged pointer as the address. They write back the pointer plus 1 or plus 2 on `wb_sel`/`wb_data`.
- R4: Modes 5 and 6 (pre-decrement) write back the pointer minus 1 or minus 2, and they use that new value as the address.
- R5: Modes 7, 8 and 9 add the sign-extended A, the sign-extended B, or the 16-bit D = {A,B} to the pointer.
- R6: Mode 10 adds the sign-extended low byte of `offset` to `pc`. Mode 11 adds the full `offset` to `pc`. Neither mode writes back. Codes 12 to 15 behave as mode 0.
- R7: An indirect request raises `ptr_fetch_req` in the cycle after `req`, with the computed address on `ptr_fetch_addr`. The request and the address hold until `ptr_fetch_ack`. The high byte comes first and the low byte second, from that address plus 1.
- R8: The cycle after the second acknowledge, `ea` is {high byte, low byte} with `ea_valid` high, and `ptr_fetch_req` is low. Any write-back is issued exactly once, in that same cycle.
- R9: A `req` that arrives while a pointer fetch is outstanding is ignored. It produces no address and no write-back.
- R10: All address and write-back arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle request strobe |
| mode | input | 4 | Addressing form code |
| base_sel | input | 2 | Pointer select, 0=X 1=Y 2=U 3=S |
| indirect | input | 1 | Fetch a pointer at the computed address |
| ptr_x | input | 16 | Pointer register X |
| ptr_y | input | 16 | Pointer register Y |
| ptr_u | input | 16 | Pointer register U |
| ptr_s | input | 16 | Pointer register S |
| acc_a | input | 8 | Accumulator A (high half of D) |
| acc_b | input | 8 | Accumulator B (low half of D) |
| pc | input | 16 | Program counter |
| offset | input | 16 | Constant offset |
| ptr_fetch_req | output | 1 | Pointer byte read request, the extra-fetch flag |
| ptr_fetch_addr | output | 16 | Byte address of the pointer read |
| ptr_fetch_ack | input | 1 | Read data valid |
| ptr_fetch_data | input | 8 | Read data byte |
| ea_valid | output | 1 | Effective address valid |
| ea | output | 16 | Effective address |
| wb_valid | output | 1 | Pointer write-back request |
| wb_sel | output | 2 | Pointer to update |
| wb_data | output | 16 | New pointer value |

## Verification
A direct form has its address and write-back due one cycle after the `req` edge. An indirect form raises the fetch request one cycle after `req`. It moves to the second byte one cycle after the first acknowledge, and it delivers the address and write-back one cycle after the second acknowledge. The bench keeps a behavioural model that advances on the same rising edge as the design. It compares every output at the following falling edge, so each expected value is sampled in exactly the cycle it is due. The memory responder varies its acknowledge delay from 0 to 3 cycles, so that request holding is exercised.

// File: rtl/eag_pkg.sv
package eag_pkg;

   typedef enum logic [3:0] {
      EA_ZERO  = 4'd0,
      EA_OFF8  = 4'd1,
      EA_OFF16 = 4'd2,
      EA_INC1  = 4'd3,
      EA_INC2  = 4'd4,
      EA_DEC1  = 4'd5,
      EA_DEC2  = 4'd6,
      EA_ACCA  = 4'd7,
      EA_ACCB  = 4'd8,
      EA_ACCD  = 4'd9,
      EA_PC8   = 4'd10,
      EA_PC16  = 4'd11
   } ea_mode_e;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_HI   = 2'd1,
      FS_LO   = 2'd2
   } fetch_st_e;

endpackage

// File: rtl/eag_operand_sel.sv
module eag_operand_sel
   import eag_pkg::*;
#(
   parameter int AW   = 16,
   parameter int DW   = 8,
   parameter int NPTR = 4,
   localparam int SW  = $clog2(NPTR)
) (
   input  logic [3:0]         mode_i,
   input  logic [SW-1:0]      sel_i,
   input  logic [NPTR*AW-1:0] ptrs_i,
   input  logic [DW-1:0]      acc_a_i,
   input  logic [DW-1:0]      acc_b_i,
   input  logic [AW-1:0]      pc_i,
   input  logic [AW-1:0]      off_i,
   output logic [AW-1:0]      base_o,
   output logic [AW-1:0]      addend_o,
   output logic [AW-1:0]      step_o,
   output logic               pre_o,
   output logic               has_wb_o
);

   logic [AW-1:0] ptr_arr [NPTR];
   logic [AW-1:0] ptr_sel;
   logic [AW-1:0] off_short, a_ext, b_ext, d_full;

   for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
      assign ptr_arr[gi] = ptrs_i[gi*AW +: AW];
   end

   assign ptr_sel   = ptr_arr[sel_i];
   assign off_short = {{(AW-DW){off_i[DW-1]}}, off_i[DW-1:0]};
   assign a_ext     = {{(AW-DW){acc_a_i[DW-1]}}, acc_a_i};
   assign b_ext     = {{(AW-DW){acc_b_i[DW-1]}}, acc_b_i};
   assign d_full    = {acc_a_i, acc_b_i};

   always_comb begin
      base_o   = ptr_sel;
      addend_o = '0;
      step_o   = '0;
      pre_o    = 1'b0;
      has_wb_o = 1'b0;
      case (ea_mode_e'(mode_i))
         EA_OFF8:  addend_o = off_short;
         EA_OFF16: addend_o = off_i;
         EA_INC1: begin step_o = AW'(1); has_wb_o = 1'b1; end
         EA_INC2: begin step_o = AW'(2); has_wb_o = 1'b1; end
         EA_DEC1: begin step_o = '1; pre_o = 1'b1; has_wb_o = 1'b1; end
         EA_DEC2: begin step_o = ~AW'(1); pre_o = 1'b1; has_wb_o = 1'b1; end
         EA_ACCA:  addend_o = a_ext;
         EA_ACCB:  addend_o = b_ext;
         EA_ACCD:  addend_o = d_full;
         EA_PC8:  begin base_o = pc_i; addend_o = off_short; end
         EA_PC16: begin base_o = pc_i; addend_o = off_i; end
         default: ;
      endcase
   end

endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] addend_i,
   input  logic [AW-1:0] step_i,
   input  logic          pre_i,
   output logic [AW-1:0] addr_o,
   output logic [AW-1:0] wb_val_o
);

   logic [AW-1:0] offset_sum;

   // both sums drop the carry out: modulo 2^AW wrap
   assign offset_sum = base_i + addend_i;
   assign wb_val_o   = base_i + step_i;
   assign addr_o     = pre_i ? wb_val_o : offset_sum;

endmodule

// File: rtl/eag_ptr_fetch.sv
module eag_ptr_fetch
   import eag_pkg::*;
#(
   parameter int AW       = 16,
   parameter int DW       = 8,
   parameter bit HI_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] addr_i,
   output logic          rd_req_o,
   output logic [AW-1:0] rd_addr_o,
   input  logic          rd_ack_i,
   input  logic [DW-1:0] rd_data_i,
   output logic          done_o,
   output logic [AW-1:0] ptr_o
);

   fetch_st_e     st_q;
   logic [AW-1:0] base_q;
   logic [DW-1:0] first_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= FS_IDLE;
         base_q  <= '0;
         first_q <= '0;
      end else begin
         case (st_q)
            FS_IDLE: if (start_i) begin
               st_q   <= FS_HI;
               base_q <= addr_i;
            end
            FS_HI: if (rd_ack_i) begin
               st_q    <= FS_LO;
               first_q <= rd_data_i;
            end
            FS_LO: if (rd_ack_i) st_q <= FS_IDLE;
            default: st_q <= FS_IDLE;
         endcase
      end
   end

   assign rd_req_o  = (st_q != FS_IDLE);
   assign rd_addr_o = (st_q == FS_LO) ? base_q + AW'(1) : base_q;
   assign done_o    = (st_q == FS_LO) && rd_ack_i;

   if (HI_FIRST) begin : g_hi_first
      assign ptr_o = {first_q, rd_data_i};
   end else begin : g_lo_first
      assign ptr_o = {rd_data_i, first_q};
   end

   // R7: a pending read keeps its request and address until acknowledged
   assert_read_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

   // R7: the second byte is read from the next address up
   assert_second_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FS_HI && rd_ack_i) |=> (rd_req_o && rd_addr_o == $past(rd_addr_o) + AW'(1)));

endmodule

// File: rtl/eag_indexed_top.sv
module eag_indexed_top
   import eag_pkg::*;
#(
   parameter int AW           = 16,
   parameter int DW           = 8,
   parameter bit PTR_HI_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [3:0]    mode,
   input  logic [1:0]    base_sel,
   input  logic          indirect,
   input  logic [AW-1:0] ptr_x,
   input  logic [AW-1:0] ptr_y,
   input  logic [AW-1:0] ptr_u,
   input  logic [AW-1:0] ptr_s,
   input  logic [DW-1:0] acc_a,
   input  logic [DW-1:0] acc_b,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] offset,
   output logic          ptr_fetch_req,
   output logic [AW-1:0] ptr_fetch_addr,
   input  logic          ptr_fetch_ack,
   input  logic [DW-1:0] ptr_fetch_data,
   output logic          ea_valid,
   output logic [AW-1:0] ea,
   output logic          wb_valid,
   output logic [1:0]    wb_sel,
   output logic [AW-1:0] wb_data
);

   localparam int NPTR = 4;
   localparam int SW   = $clog2(NPTR);

   if (AW != 2*DW) begin : g_bad_width
      $error("address width must be twice the data width");
   end
   if (DW < 2) begin : g_bad_data
      $error("data width too small");
   end

   logic [AW-1:0] base_v, addend_v, step_v, addr_v, wbv_v, ptr_v;
   logic          pre_v, has_wb_v, busy, fetch_done, accept, fetch_go;
   logic          pend_wb_q;
   logic [SW-1:0] pend_sel_q;
   logic [AW-1:0] pend_data_q;

   eag_operand_sel #(.AW(AW), .DW(DW), .NPTR(NPTR)) u_sel (
      .mode_i   (mode),
      .sel_i    (base_sel),
      .ptrs_i   ({ptr_s, ptr_u, ptr_y, ptr_x}),
      .acc_a_i  (acc_a),
      .acc_b_i  (acc_b),
      .pc_i     (pc),
      .off_i    (offset),
      .base_o   (base_v),
      .addend_o (addend_v),
      .step_o   (step_v),
      .pre_o    (pre_v),
      .has_wb_o (has_wb_v)
   );

   eag_addr_calc #(.AW(AW)) u_calc (
      .base_i   (base_v),
      .addend_i (addend_v),
      .step_i   (step_v),
      .pre_i    (pre_v),
      .addr_o   (addr_v),
      .wb_val_o (wbv_v)
   );

   assign busy     = ptr_fetch_req;
   assign accept   = req && !busy;
   assign fetch_go = accept && indirect;

   eag_ptr_fetch #(.AW(AW), .DW(DW), .HI_FIRST(PTR_HI_FIRST)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (fetch_go),
      .addr_i    (addr_v),
      .rd_req_o  (ptr_fetch_req),
      .rd_addr_o (ptr_fetch_addr),
      .rd_ack_i  (ptr_fetch_ack),
      .rd_data_i (ptr_fetch_data),
      .done_o    (fetch_done),
      .ptr_o     (ptr_v)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea_valid    <= 1'b0;
         ea          <= '0;
         wb_valid    <= 1'b0;
         wb_sel      <= '0;
         wb_data     <= '0;
         pend_wb_q   <= 1'b0;
         pend_sel_q  <= '0;
         pend_data_q <= '0;
      end else begin
         ea_valid <= 1'b0;
         wb_valid <= 1'b0;
         if (fetch_done) begin
            ea_valid  <= 1'b1;
            ea        <= ptr_v;
            wb_valid  <= pend_wb_q;
            wb_sel    <= pend_sel_q;
            wb_data   <= pend_data_q;
            pend_wb_q <= 1'b0;
         end else if (accept) begin
            if (indirect) begin
               pend_wb_q   <= has_wb_v;
               pend_sel_q  <= base_sel;
               pend_data_q <= wbv_v;
            end else begin
               ea_valid <= 1'b1;
               ea       <= addr_v;
               wb_valid <= has_wb_v;
               wb_sel   <= base_sel;
               wb_data  <= wbv_v;
            end
         end
      end
   end

   // R8: a write-back never appears without its effective address
   assert_wb_with_ea_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> ea_valid);

   // R9: no address is delivered while a pointer fetch is still outstanding
   assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ea_valid && ptr_fetch_req));

   // R8: the final indirect address follows the last acknowledge
   assert_done_then_ea_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_fetch_req && ptr_fetch_ack && ptr_fetch_addr == $past(ptr_fetch_addr) + AW'(1))
      |=> (ea_valid && !ptr_fetch_req));

endmodule

// File: tb/eag_indexed_top_test.sv
module eag_indexed_top_test;

   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [3:0]  mode = '0;
   logic [1:0]  base_sel = '0;
   logic        indirect = 1'b0;
   logic [15:0] ptr_x = 16'h1000, ptr_y = 16'h2000, ptr_u = 16'h3000, ptr_s = 16'h4000;
   logic [7:0]  acc_a = 8'h00, acc_b = 8'h00;
   logic [15:0] pc = 16'h8000, offset = 16'h0000;
   logic        ptr_fetch_req;
   logic [15:0] ptr_fetch_addr;
   logic        ptr_fetch_ack = 1'b0;
   logic [7:0]  ptr_fetch_data = 8'h00;
   logic        ea_valid, wb_valid;
   logic [15:0] ea, wb_data;
   logic [1:0]  wb_sel;

   int compared = 0, mismatched = 0, lat = 0, wait_cnt = 0;
   bit done_flag = 0;
   string cur_tag = "R1", m_tag = "R1";

   // reference model state
   int m_st = 0, m_ptr = 0, m_hi = 0, p_wbd = 0, p_sel = 0;
   bit p_wbv = 0;
   bit e_eav = 0, e_wbv = 0, e_rq = 0;
   int e_ea = 0, e_wbd = 0, e_sel = 0, e_ra = 0;

   eag_indexed_top uut (
      .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .base_sel(base_sel),
      .indirect(indirect), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_u(ptr_u), .ptr_s(ptr_s),
      .acc_a(acc_a), .acc_b(acc_b), .pc(pc), .offset(offset),
      .ptr_fetch_req(ptr_fetch_req), .ptr_fetch_addr(ptr_fetch_addr),
      .ptr_fetch_ack(ptr_fetch_ack), .ptr_fetch_data(ptr_fetch_data),
      .ea_valid(ea_valid), .ea(ea), .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_data(wb_data)
   );

   always #(CLK_NS/2) clk = ~clk;

   function automatic int sx8(input int v);
      return (v & 8'h80) ? (v & 8'hFF) - 256 : (v & 8'hFF);
   endfunction

   function automatic int mem_byte(input int a);
      return ((a & 8'hFF) ^ ((a >> 8) & 8'hFF) ^ 8'hA5) & 8'hFF;
   endfunction

   function automatic void ref_calc(output int addr, output bit hw, output int wbd);
      int b;
      case (base_sel)
         2'd0: b = int'(ptr_x);
         2'd1: b = int'(ptr_y);
         2'd2: b = int'(ptr_u);
         default: b = int'(ptr_s);
      endcase
      hw = 0; wbd = b; addr = b;
      case (int'(mode))
         1: addr = b + sx8(int'(offset));
         2: addr = b + int'(offset);
         3: begin hw = 1; wbd = b + 1; end
         4: begin hw = 1; wbd = b + 2; end
         5: begin hw = 1; wbd = b - 1; addr = wbd; end
         6: begin hw = 1; wbd = b - 2; addr = wbd; end
         7: addr = b + sx8(int'(acc_a));
         8: addr = b + sx8(int'(acc_b));
         9: addr = b + int'(acc_a) * 256 + int'(acc_b);
         10: addr = int'(pc) + sx8(int'(offset));
         11: addr = int'(pc) + int'(offset);
         default: ;
      endcase
      addr = addr & 16'hFFFF;
      wbd  = wbd & 16'hFFFF;
   endfunction

   always @(posedge clk) begin
      int a, w;
      bit h;
      if (!rst_n) begin
         m_st = 0; e_eav = 0; e_wbv = 0; m_tag = "R1";
      end else begin
         e_eav = 0; e_wbv = 0;
         case (m_st)
            0: if (req) begin
               ref_calc(a, h, w);
               m_tag = cur_tag;
               if (!indirect) begin
                  e_eav = 1; e_ea = a; e_wbv = h; e_sel = int'(base_sel); e_wbd = w;
               end else begin
                  m_st = 1; m_ptr = a; p_wbv = h; p_sel = int'(base_sel); p_wbd = w;
               end
            end
            1: begin
               if (req) m_tag = "R9";
               if (ptr_fetch_ack) begin m_hi = int'(ptr_fetch_data); m_st = 2; end
            end
            default: begin
               if (req) m_tag = "R9";
               if (ptr_fetch_ack) begin
                  e_eav = 1; e_ea = m_hi * 256 + int'(ptr_fetch_data);
                  e_wbv = p_wbv; e_sel = p_sel; e_wbd = p_wbd; m_st = 0;
               end
            end
         endcase
      end
      e_rq = (m_st != 0);
      e_ra = (m_st == 1) ? m_ptr : ((m_ptr + 1) & 16'hFFFF);
   end

   task automatic chk(input string what, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", m_tag, what, act, exp, $time);
      end
   endtask

   // compare at the falling edge, half a cycle after outputs settle
   always @(negedge clk) begin
      if (!done_flag) begin
         chk("ea_valid", int'(ea_valid), int'(e_eav));
         chk("wb_valid", int'(wb_valid), int'(e_wbv));
         chk("fetch_req", int'(ptr_fetch_req), int'(e_rq));
         if (e_eav) chk("ea", int'(ea), e_ea);
         if (e_wbv) begin
            chk("wb_sel", int'(wb_sel), e_sel);
            chk("wb_data", int'(wb_data), e_wbd);
         end
         if (e_rq) chk("fetch_addr", int'(ptr_fetch_addr), e_ra);
      end
   end

   // memory responder with a programmable acknowledge delay
   always @(negedge clk) begin
      if (ptr_fetch_ack) begin
         ptr_fetch_ack <= 1'b0;
      end else if (ptr_fetch_req) begin
         if (wait_cnt >= lat) begin
            ptr_fetch_ack  <= 1'b1;
            ptr_fetch_data <= 8'(mem_byte(int'(ptr_fetch_addr)));
            wait_cnt = 0;
         end else wait_cnt++;
      end
   end

   task automatic issue(input string tag, input int md, input int sel, input bit ind);
      @(negedge clk);
      cur_tag = tag; mode = 4'(md); base_sel = 2'(sel); indirect = ind; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R2: direct and constant offsets, every pointer
      offset = 16'h00F0;
      for (int s = 0; s < 4; s++) begin
         issue("R2", 0, s, 0);
         issue("R2", 1, s, 0);
         issue("R2", 2, s, 0);
      end
      offset = 16'h0012;
      issue("R2", 1, 1, 0);
      // R3 / R4: auto-increment and auto-decrement
      for (int s = 0; s < 4; s++) begin
         issue("R3", 3, s, 0);
         issue("R3", 4, s, 0);
         issue("R4", 5, s, 0);
         issue("R4", 6, s, 0);
      end
      // R5: accumulator offsets, both signs
      acc_a = 8'h85; acc_b = 8'h7F;
      for (int m = 7; m <= 9; m++) issue("R5", m, 2, 0);
      acc_a = 8'h12; acc_b = 8'hC0;
      for (int m = 7; m <= 9; m++) issue("R5", m, 3, 0);
      // R6: PC-relative and reserved codes
      offset = 16'hFF80; issue("R6", 10, 0, 0); issue("R6", 11, 0, 0);
      offset = 16'h0170; issue("R6", 10, 1, 0); issue("R6", 11, 1, 0);
      issue("R6", 13, 2, 0);
      issue("R6", 15, 1, 0);
      // R10: wraparound at both ends
      ptr_x = 16'hFFFF; ptr_y = 16'h0000; ptr_u = 16'h0001; offset = 16'h7FFF;
      issue("R10", 4, 0, 0);
      issue("R10", 6, 1, 0);
      issue("R10", 6, 2, 0);
      issue("R10", 2, 0, 0);
      ptr_x = 16'h1000; ptr_y = 16'h2000; ptr_u = 16'h3000;
      // R7 / R8: indirect forms with several acknowledge delays
      for (int l = 0; l < 4; l++) begin
         lat = l;
         offset = 16'h0004;
         issue("R7", 1, 0, 1);
         issue("R7", 0, 1, 1);
         issue("R8", 3, 2, 1);
         issue("R8", 6, 3, 1);
         issue("R7", 11, 0, 1);
      end
      ptr_x = 16'hFFFF; lat = 1;
      issue("R10", 0, 0, 1);
      ptr_x = 16'h1000;
      // R9: request during an outstanding fetch is dropped
      lat = 3;
      @(negedge clk);
      cur_tag = "R9"; mode = 4'd4; base_sel = 2'd3; indirect = 1'b1; req = 1'b1;
      @(negedge clk);
      mode = 4'd3; base_sel = 2'd0; indirect = 1'b0;
      @(negedge clk);
      req = 1'b0;
      @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (15) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      compared++; mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

endmodule